// File: doc/BRIEF.md
# Converter Serial Port Slave

This block is the digital half of a multichannel successive-approximation converter's serial port. A host drives an active-low chip select, a serial clock and a serial data line. The block oversamples these three lines with its own faster system clock. It decodes each 16-clock frame into an optional write to one of three configuration registers: a 12-bit control register and two 8-bit registers that hold the channel sequence and the input range.

During the same frame the block returns a 16-bit word on a serial output that has its own output enable, so that the pad can be put in three-state. The word carries a channel identifier, a sign bit and a 12-bit result. These come from parallel inputs that stand in for the analog core, and they are captured when the frame opens. A hold output tells the sampling stage when to hold and when to track.

The three registers commit at different points in the frame. If chip select rises early, a write survives only when its commit point has already passed.

Top module: `adc_port_slave`

## Requirements
- R1: After reset the control, sequence and range registers read zero, and `dout_oe_o` and `hold_o` are low.
- R2: On a falling edge of `cs_ni`, `dout_oe_o` goes high and `dout_o` shows 0.
- R3: The output word is {0, chan[1:0], sign, result[11:0]}, sent MSB first. Bit 15 is shown at the chip-select fall, and each later bit is shown after the next serial-clock falling edge.
- R4: `dout_oe_o` drops after the 16th serial-clock falling edge.
- R5: `din_i` is captured on serial-clock falling edges. The first three bits form the header {write, sel[1:0]}, and sel 00 addresses control. The control register takes the next 12 bits, MSB first, and commits on the 15th serial-clock rising edge.
- R6: Sel 10 addresses the sequence register and sel 01 the range register. Either one takes the 8 bits that follow the header and commits on the 11th serial-clock falling edge.
- R7: If the write bit is 0, or if sel is 11, no register changes.
- R8: If `cs_ni` rises before the frame ends, `dout_oe_o` drops at once. A write whose commit edge has already passed keeps its new value, and a write whose commit edge has not passed leaves its register unchanged.
- R9: `hold_o` rises at the chip-select fall. It falls on the 14th serial-clock rising edge, or on an early chip-select rise.
- R10: The channel, sign and result inputs are latched at the chip-select fall. Changing them later in the frame does not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| din_i | input | 1 | Serial write data |
| chan_i | input | 2 | Channel identifier of the result |
| sign_i | input | 1 | Sign of the result |
| result_i | input | 12 | Conversion result |
| dout_o | output | 1 | Serial read data |
| dout_oe_o | output | 1 | Output enable for the serial read data |
| hold_o | output | 1 | 1 = hold, 0 = track |
| ctrl_o | output | 12 | Control register |
| seq_o | output | 8 | Sequence register |
| range_o | output | 8 | Range register |

## Verification
A falling-edge counter that is off by one shows up in the same frame in two ways: the output word appears shifted by one bit, and the output enable drops one serial clock early or late. A wrong commit index has a different effect. It puts shifted data into a register, or it changes which writes survive an early chip-select rise, and this can be read at the register ports as soon as the frame ends. A header that is decoded wrongly sends the data to the wrong register, which the next register comparison shows.

// File: rtl/adcp_pkg.sv
package adcp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'b00,
    SEL_RANGE = 2'b01,
    SEL_SEQ   = 2'b10,
    SEL_NONE  = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/adcp_sync.sv
module adcp_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/adcp_frame.sv
module adcp_frame
  import adcp_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned HDR_W     = 3,
  parameter int unsigned CTRL_W    = 12,
  parameter int unsigned SR_W      = 8,
  parameter int unsigned HOLD_RISE = 14,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sclk_rise_i,
  input  logic              din_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  fall_cnt_o,
  output logic              hold_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [SR_W-1:0]   seq_o,
  output logic [SR_W-1:0]   range_o
);
  localparam int unsigned DSR_W     = HDR_W + CTRL_W;
  localparam int unsigned SR_FALL   = HDR_W + SR_W;
  localparam int unsigned CTRL_RISE = HDR_W + CTRL_W;

  logic              active_q, hold_q;
  logic [CNT_W-1:0]  fall_cnt_q, rise_cnt_q;
  logic [DSR_W-1:0]  din_sr_q;
  logic [DSR_W:0]    din_nv;
  logic [CTRL_W-1:0] ctrl_q;
  logic [SR_W-1:0]   seq_q, range_q;
  logic [HDR_W-1:0]  hdr_sr, hdr_ct;
  logic              sr_hit, ct_hit;

  assign din_nv = {din_sr_q, din_i};
  // header as seen at each commit point
  assign hdr_sr = din_nv[SR_FALL-1 -: HDR_W];
  assign hdr_ct = din_sr_q[DSR_W-1 -: HDR_W];
  assign sr_hit = active_q && sclk_fall_i && !cs_rise_i && (fall_cnt_q == CNT_W'(SR_FALL - 1));
  assign ct_hit = active_q && sclk_rise_i && !cs_rise_i && (rise_cnt_q == CNT_W'(CTRL_RISE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      hold_q     <= 1'b0;
      fall_cnt_q <= '0;
      rise_cnt_q <= '0;
      din_sr_q   <= '0;
    end else if (cs_fall_i) begin
      active_q   <= 1'b1;
      hold_q     <= 1'b1;
      fall_cnt_q <= '0;
      rise_cnt_q <= '0;
    end else if (cs_rise_i) begin
      active_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (active_q) begin
      if (sclk_fall_i) begin
        fall_cnt_q <= fall_cnt_q + 1'b1;
        din_sr_q   <= din_nv[DSR_W-1:0];
        if (fall_cnt_q == CNT_W'(FRAME_LEN - 1)) active_q <= 1'b0;
      end
      if (sclk_rise_i) begin
        rise_cnt_q <= rise_cnt_q + 1'b1;
        if (rise_cnt_q == CNT_W'(HOLD_RISE - 1)) hold_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      seq_q   <= '0;
      range_q <= '0;
    end else begin
      if (sr_hit && hdr_sr[HDR_W-1]) begin
        if (reg_sel_e'(hdr_sr[1:0]) == SEL_SEQ)   seq_q   <= din_nv[SR_W-1:0];
        if (reg_sel_e'(hdr_sr[1:0]) == SEL_RANGE) range_q <= din_nv[SR_W-1:0];
      end
      if (ct_hit && hdr_ct[HDR_W-1] && reg_sel_e'(hdr_ct[1:0]) == SEL_CTRL)
        ctrl_q <= din_sr_q[CTRL_W-1:0];
    end
  end

  assign active_o   = active_q;
  assign fall_cnt_o = fall_cnt_q;
  assign hold_o     = hold_q;
  assign ctrl_o     = ctrl_q;
  assign seq_o      = seq_q;
  assign range_o    = range_q;

  p_ctrl_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> $past(sclk_rise_i && active_q && rise_cnt_q == CNT_W'(CTRL_RISE - 1)));
  p_seq_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seq_q) |-> $past(sclk_fall_i && active_q && fall_cnt_q == CNT_W'(SR_FALL - 1)));
  p_range_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(range_q) |-> $past(sclk_fall_i && active_q && fall_cnt_q == CNT_W'(SR_FALL - 1)));
  p_hold_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> hold_q);
  p_hold_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && !cs_fall_i) |=> !hold_q);
endmodule

// File: rtl/adcp_shifter.sv
module adcp_shifter #(
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned CH_W      = 2,
  parameter int unsigned RES_W     = 12,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1),
  localparam int unsigned WORD_W   = 2 + CH_W + RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] fall_cnt_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             sign_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o,
  output logic             dout_oe_o
);
  logic [WORD_W-1:0] word_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      oe_q   <= 1'b0;
    end else if (cs_fall_i) begin
      word_q <= {1'b0, chan_i, sign_i, result_i};
      oe_q   <= 1'b1;
    end else if (cs_rise_i) begin
      oe_q <= 1'b0;
    end else if (sclk_fall_i && active_i) begin
      word_q <= {word_q[WORD_W-2:0], 1'b0};
      if (fall_cnt_i == CNT_W'(FRAME_LEN - 1)) oe_q <= 1'b0;
    end
  end

  assign dout_o    = oe_q & word_q[WORD_W-1];
  assign dout_oe_o = oe_q;

  p_oe_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (dout_oe_o && !dout_o));
  p_abort_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && !cs_fall_i) |=> !dout_oe_o);
  p_oe_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !cs_fall_i) |=> !dout_oe_o);
endmodule

// File: rtl/adc_port_slave.sv
module adc_port_slave #(
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned HDR_W     = 3,
  parameter int unsigned CTRL_W    = 12,
  parameter int unsigned SR_W      = 8,
  parameter int unsigned CH_W      = 2,
  parameter int unsigned RES_W     = 12,
  parameter int unsigned HOLD_RISE = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              sign_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              hold_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [SR_W-1:0]   seq_o,
  output logic [SR_W-1:0]   range_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);

  logic [2:0]       pins_s;
  logic             cs_d_q, sclk_d_q;
  logic             cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic             active;
  logic [CNT_W-1:0] fall_cnt;

  adcp_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, din_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q   <= 1'b1;
      sclk_d_q <= 1'b1;
    end else begin
      cs_d_q   <= pins_s[2];
      sclk_d_q <= pins_s[1];
    end
  end

  assign cs_fall   = cs_d_q & ~pins_s[2];
  assign cs_rise   = ~cs_d_q & pins_s[2];
  assign sclk_fall = sclk_d_q & ~pins_s[1] & ~pins_s[2];
  assign sclk_rise = ~sclk_d_q & pins_s[1] & ~pins_s[2];

  adcp_frame #(
    .FRAME_LEN(FRAME_LEN), .HDR_W(HDR_W), .CTRL_W(CTRL_W),
    .SR_W(SR_W), .HOLD_RISE(HOLD_RISE)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .sclk_fall_i(sclk_fall),
    .sclk_rise_i(sclk_rise),
    .din_i      (pins_s[0]),
    .active_o   (active),
    .fall_cnt_o (fall_cnt),
    .hold_o     (hold_o),
    .ctrl_o     (ctrl_o),
    .seq_o      (seq_o),
    .range_o    (range_o)
  );

  adcp_shifter #(
    .FRAME_LEN(FRAME_LEN), .CH_W(CH_W), .RES_W(RES_W)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .sclk_fall_i(sclk_fall),
    .active_i   (active),
    .fall_cnt_i (fall_cnt),
    .chan_i     (chan_i),
    .sign_i     (sign_i),
    .result_i   (result_i),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o)
  );
endmodule

// File: tb/adc_port_slave_test.sv
module adc_port_slave_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic [1:0]  chan = '0;
  logic        sign = 1'b0;
  logic [11:0] result = '0;
  logic        dout, dout_oe, hold;
  logic [11:0] ctrl;
  logic [7:0]  seq, rng;

  int checks = 0, bad = 0;
  bit done = 0;

  logic [15:0] got;
  logic oe_start, d_start, hold_start, oe16, hold13, hold14, oe_end, hold_end;
  logic [11:0] m_ctrl = '0;
  logic [7:0]  m_seq = '0, m_rng = '0;

  always #4 clk = ~clk;

  adc_port_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .chan_i(chan), .sign_i(sign), .result_i(result),
    .dout_o(dout), .dout_oe_o(dout_oe), .hold_o(hold),
    .ctrl_o(ctrl), .seq_o(seq), .range_o(rng)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model from R5/R6/R7/R8: commits happen only if enough edges occur
  task automatic model(input logic [15:0] w, input int n);
    if (w[15]) begin
      if (w[14:13] == 2'b00 && n >= 15) m_ctrl = w[12:1];
      if (w[14:13] == 2'b10 && n >= 11) m_seq  = w[12:5];
      if (w[14:13] == 2'b01 && n >= 11) m_rng  = w[12:5];
    end
  endtask

  task automatic run_frame(input logic [15:0] w, input int n);
    got = '0;
    @(negedge clk) cs_n = 1'b0;
    wclk(8);
    oe_start = dout_oe; d_start = dout; hold_start = hold;
    chan = ~chan; sign = ~sign; result = ~result;  // R10 disturb after latch
    for (int k = 0; k < n; k++) begin
      din = w[15-k];
      wclk(6);
      got[15-k] = dout;
      sclk = 1'b0;
      wclk(8);
      if (k == 15) oe16 = dout_oe;
      sclk = 1'b1;
      wclk(8);
      if (k == 12) hold13 = hold;
      if (k == 13) hold14 = hold;
    end
    cs_n = 1'b1;
    wclk(8);
    oe_end = dout_oe; hold_end = hold;
    model(w, n);
  endtask

  task automatic regs_chk(input string req);
    chk(ctrl == m_ctrl, req, {4'h0, ctrl}, {4'h0, m_ctrl});
    chk(seq == m_seq, req, {8'h0, seq}, {8'h0, m_seq});
    chk(rng == m_rng, req, {8'h0, rng}, {8'h0, m_rng});
  endtask

  // header {write, sel}: sel 00 ctrl, 10 seq, 01 range, 11 none
  localparam logic [15:0] DIN_TAB [6] = '{
    {1'b1, 2'b00, 12'hA5C, 1'b0},
    {1'b1, 2'b10, 8'h9E, 5'h00},
    {1'b1, 2'b01, 8'h37, 5'h1F},
    {1'b0, 2'b00, 12'h123, 1'b1},
    {1'b1, 2'b11, 12'hFFF, 1'b1},
    {1'b0, 2'b10, 8'h44, 5'h00}
  };
  localparam logic [1:0]  CH_TAB  [6] = '{2'd2, 2'd1, 2'd3, 2'd0, 2'd2, 2'd1};
  localparam logic        SG_TAB  [6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [11:0] RES_TAB [6] = '{12'h3C7, 12'hFFF, 12'h001, 12'h800, 12'h555, 12'hAAA};

  initial begin
    wclk(5);
    // R1 reset state
    chk(ctrl == 12'h0 && seq == 8'h0 && rng == 8'h0, "R1 regs", {ctrl[7:0], seq}, 16'h0);
    chk(!dout_oe && !hold, "R1 oe/hold", {14'h0, dout_oe, hold}, 16'h0);
    rst_n = 1'b1;
    wclk(4);

    for (int i = 0; i < 6; i++) begin
      logic [15:0] exp_w;
      chan = CH_TAB[i]; sign = SG_TAB[i]; result = RES_TAB[i];
      exp_w = {1'b0, CH_TAB[i], SG_TAB[i], RES_TAB[i]};
      run_frame(DIN_TAB[i], 16);
      chk(oe_start && !d_start, "R2 start", {14'h0, oe_start, d_start}, 16'h2);
      chk(got == exp_w, "R3/R10 word", got, exp_w);
      chk(!oe16 && !oe_end, "R4 oe off", {14'h0, oe16, oe_end}, 16'h0);
      chk(hold_start && hold13 && !hold14, "R9 hold", {13'h0, hold_start, hold13, hold14}, 16'h6);
      regs_chk((DIN_TAB[i][15] && DIN_TAB[i][14:13] != 2'b11) ? "R5/R6 commit" : "R7 no write");
    end

    // R8 aborts
    run_frame({1'b1, 2'b10, 8'h5A, 5'h00}, 11);
    chk(!oe_end && !hold_end, "R8 abort oe/R9 hold", {14'h0, oe_end, hold_end}, 16'h0);
    chk(seq == 8'h5A, "R8 seq kept at 11 falls", {8'h0, seq}, 16'h005A);
    run_frame({1'b1, 2'b01, 8'hC3, 5'h00}, 10);
    chk(rng == m_rng && rng != 8'hC3, "R8 range lost at 10 falls", {8'h0, rng}, {8'h0, m_rng});
    run_frame({1'b1, 2'b00, 12'h6E1, 1'b0}, 14);
    chk(ctrl == m_ctrl && ctrl != 12'h6E1, "R8 ctrl lost at 14 rises", {4'h0, ctrl}, {4'h0, m_ctrl});
    chk(!oe_end, "R8 oe after abort", {15'h0, oe_end}, 16'h0);
    run_frame({1'b1, 2'b00, 12'h6E1, 1'b0}, 15);
    chk(ctrl == 12'h6E1, "R8 ctrl kept at 15 rises", {4'h0, ctrl}, 16'h06E1);
    run_frame({1'b1, 2'b10, 8'h11, 5'h00}, 3);
    chk(!hold_end, "R9 hold abort", {15'h0, hold_end}, 16'h0);
    regs_chk("R8 early abort");

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule